// File: doc/BRIEF.md
# Start-of-Frame Flag with Frame Timer

This block raises a sticky start-of-frame interrupt flag for a full-speed USB function. The flag sets when the token decoder reports a good SOF. When a frame token is lost or damaged, the block still produces an SOF at a regular pace. Software clears the flag by writing a one to its bit position.

One counter tracks the bit times since the most recent frame event, whether that event was real or synthesized. Each real SOF restarts the counter.

Two real SOFs in a row whose spacing lies inside a window around the nominal 1 ms frame (12000 bit times) lock the block to the host. The measured spacing is then kept as the substitution period.

- When lock mode is selected and the block is locked, a missing token is replaced after that stored period. A corrupted-token strobe is replaced at once.
- Otherwise a missing token is replaced after a fixed timeout of 12043 bit times.

Top module: `sof_flag_timer`

## Requirements
- R1: A high `sof_ok` at a clock edge makes `sof_flag` high after that edge.
- R2: A write with `wr_en`=1 and `wr_clr`=1 clears `sof_flag`. A write with `wr_clr`=0, or `wr_clr`=1 without `wr_en`, leaves it unchanged.
- R3: When a set event (real or synthesized SOF) and a write-1 clear occur at the same edge, `sof_flag` ends high.
- R4: `rst_n` low (asynchronous) or `bus_reset` high (synchronous) clears `sof_flag`, drops lock and restarts the frame counter from zero.
- R5: When the block is not using lock, a synthesized SOF sets the flag on the TIMEOUT-th (default 12043) `bit_en` cycle after the last frame event. Cycles with `bit_en`=0 do not count.
- R6: A real SOF that follows another real SOF, with no synthesized SOF between them, locks the block when its spacing in bit times lies in NOMINAL±TOL (default 11940..12060, both ends included). That spacing is then stored as the period.
- R7: When locked and `lock_mode`=1, a synthesized SOF sets the flag every stored-period bit times while no token arrives. With `lock_mode`=0 the timeout of R5 applies even while locked.
- R8: When locked and `lock_mode`=1, a `sof_bad` strobe acts as an SOF at that edge and restarts the counter. Otherwise `sof_bad` has no effect.
- R9: Every real SOF restarts the frame counter, so the next synthesized SOF is timed from it.
- R10: A measured real-SOF spacing outside the window clears lock, and timing falls back to the timeout of R5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Local asynchronous reset, active low |
| bus_reset | input | 1 | USB bus reset, synchronous, active high |
| bit_en | input | 1 | One-cycle enable per full-speed bit time |
| sof_ok | input | 1 | Strobe for a valid SOF token |
| sof_bad | input | 1 | Strobe for a corrupted SOF token |
| lock_mode | input | 1 | 1 selects the learned host period for substitution |
| wr_en | input | 1 | Write strobe for the flag register |
| wr_clr | input | 1 | Write data at the flag bit position (1 clears) |
| sof_flag | output | 1 | Sticky start-of-frame interrupt flag |

## Verification
Two of this block's functions can fall in one cycle: a set event, either a token or the frame timer expiring, and a software write-one clear. The bench drives `sof_ok` and a clearing write in the same cycle and expects the flag to remain high.

The timer paths are judged by counting bit times from a known frame event. The flag is sampled one bit time before and exactly at the expected substitution point, in locked, unlocked and boundary-window cases.

// File: rtl/sof_flag_timer.sv
module sof_flag_timer #(
  parameter int NOMINAL = 12000,
  parameter int TOL     = 60,
  parameter int TIMEOUT = 12043
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_reset,
  input  logic bit_en,
  input  logic sof_ok,
  input  logic sof_bad,
  input  logic lock_mode,
  input  logic wr_en,
  input  logic wr_clr,
  output logic sof_flag
);
  localparam int CW = $clog2(TIMEOUT + 1);
  localparam logic [CW-1:0] WIN_LO = CW'(NOMINAL - TOL);
  localparam logic [CW-1:0] WIN_HI = CW'(NOMINAL + TOL);
  localparam logic [CW-1:0] TMO    = CW'(TIMEOUT);
  localparam logic [CW-1:0] ONE    = CW'(1);

  logic [CW-1:0] cnt, period;
  logic          locked, prev_real;

  wire [CW-1:0] span     = cnt + {{(CW-1){1'b0}}, bit_en};
  wire          in_win   = (span >= WIN_LO) && (span <= WIN_HI);
  wire          use_lock = lock_mode && locked;
  wire [CW-1:0] limit    = use_lock ? period : TMO;
  wire          tmo_ev   = bit_en && !sof_ok && (cnt == limit - ONE);
  wire          bad_ev   = sof_bad && use_lock && !sof_ok;
  wire          syn_ev   = tmo_ev || bad_ev;
  wire          frame_ev = sof_ok || syn_ev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     cnt <= '0;
    else if (bus_reset || frame_ev) cnt <= '0;
    else if (bit_en)                cnt <= cnt + ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked    <= 1'b0;
      prev_real <= 1'b0;
      period    <= TMO;
    end else if (bus_reset) begin
      locked    <= 1'b0;
      prev_real <= 1'b0;
      period    <= TMO;
    end else if (sof_ok) begin
      prev_real <= 1'b1;
      if (prev_real) begin
        locked <= in_win;
        if (in_win) period <= span;
      end
    end else if (syn_ev) begin
      prev_real <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 sof_flag <= 1'b0;
    else if (bus_reset)         sof_flag <= 1'b0;
    else if (frame_ev)          sof_flag <= 1'b1;
    else if (wr_en && wr_clr)   sof_flag <= 1'b0;
  end
endmodule

// File: rtl/sof_flag_timer_chk.sv
module sof_flag_timer_chk #(
  parameter int TIMEOUT = 12043,
  parameter int CW = $clog2(TIMEOUT + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_reset,
  input logic          sof_ok,
  input logic          wr_en,
  input logic          wr_clr,
  input logic          sof_flag,
  input logic          syn_ev,
  input logic [CW-1:0] cnt
);
  // R1
  set_on_sof_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sof_ok && !bus_reset |=> sof_flag);
  // R2
  clear_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_clr && !sof_ok && !syn_ev && !bus_reset |=> !sof_flag);
  // R2
  hold_without_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sof_flag && !(wr_en && wr_clr) && !bus_reset |=> sof_flag);
  // R3
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_clr && syn_ev && !bus_reset |=> sof_flag);
  // R4
  bus_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_reset |=> !sof_flag && cnt == '0);
  // R5
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < CW'(TIMEOUT));
  // R1
  rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sof_flag) |-> $past(sof_ok || syn_ev));
endmodule

bind sof_flag_timer sof_flag_timer_chk #(.TIMEOUT(TIMEOUT)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset), .sof_ok(sof_ok),
  .wr_en(wr_en), .wr_clr(wr_clr), .sof_flag(sof_flag),
  .syn_ev(syn_ev), .cnt(cnt)
);

// File: tb/test_sof_flag_timer.sv
`timescale 1ns/1ps
module test_sof_flag_timer;
  localparam int NOM = 400, TOL = 10, TMO = 443;
  localparam int HI = NOM + TOL, LO = NOM - TOL;

  logic clk = 0, rst_n = 0, bus_reset = 0, bit_en = 0, sof_ok = 0, sof_bad = 0;
  logic lock_mode = 0, wr_en = 0, wr_clr = 0;
  logic sof_flag;
  int total = 0, bad = 0;

  always #2 clk = ~clk;

  sof_flag_timer #(.NOMINAL(NOM), .TOL(TOL), .TIMEOUT(TMO)) i_sof_flag_timer (
    .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset), .bit_en(bit_en),
    .sof_ok(sof_ok), .sof_bad(sof_bad), .lock_mode(lock_mode),
    .wr_en(wr_en), .wr_clr(wr_clr), .sof_flag(sof_flag));

  // {sof_ok, sof_bad, wr_en, wr_clr, expected flag}, bit_en held low
  localparam logic [4:0] VEC [0:7] = '{
    5'b10001,  // R1 set
    5'b00101,  // R2 write 0 keeps
    5'b00110,  // R2 write 1 clears
    5'b10111,  // R3 set wins over clear
    5'b00110,  // R2 clear
    5'b01000,  // R8 bad ignored when unlocked
    5'b10001,  // R1 set
    5'b00011   // R2 clear data without strobe ignored
  };

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask
  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask
  task automatic check(input string tag, input logic exp);
    total++;
    if (sof_flag !== exp) begin
      bad++;
      $display("FAIL %s: sof_flag=%0b expected=%0b", tag, sof_flag, exp);
    end
  endtask
  task automatic fclr();
    wr_en = 1; wr_clr = 1; tick(); wr_en = 0; wr_clr = 0;
  endtask
  task automatic sof_pulse();
    sof_ok = 1; tick(); sof_ok = 0;
  endtask
  task automatic bus_rst();
    bus_reset = 1; tick(); bus_reset = 0;
  endtask

  initial begin
    ticks(190000);
    bad++; total++;
    $display("FAIL watchdog: run hung, actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk); ticks(3);
    check("R4 local reset", 1'b0);
    rst_n = 1; tick();
    check("R4 after reset release", 1'b0);

    foreach (VEC[k]) begin
      {sof_ok, sof_bad, wr_en, wr_clr} = VEC[k][4:1];
      tick();
      check($sformatf("R1/R2/R3/R8 vector %0d", k), VEC[k][0]);
      {sof_ok, sof_bad, wr_en, wr_clr} = 4'b0;
    end

    bit_en = 1;
    // R5 unlocked timeout
    bus_rst(); sof_pulse(); fclr();
    ticks(TMO - 2); check("R5 before timeout", 1'b0);
    tick();         check("R5 at timeout", 1'b1);
    // R5 bit_en gating
    bit_en = 0; fclr(); ticks(1000);
    check("R5 no count without bit_en", 1'b0);
    bit_en = 1;

    // R6 lock at upper window edge, R7 locked cadence
    bus_rst(); lock_mode = 1; sof_pulse();
    ticks(HI - 1); sof_pulse(); fclr();
    ticks(HI - 2); check("R7 before period", 1'b0);
    tick();        check("R6 R7 synth at learned period", 1'b1);
    fclr();
    ticks(HI - 2); check("R7 cadence before", 1'b0);
    tick();        check("R7 cadence repeats", 1'b1);
    // R7 lock_mode=0 uses timeout
    lock_mode = 0; fclr();
    ticks(HI - 1); check("R7 mode0 ignores period", 1'b0);
    ticks(TMO - HI - 1); check("R7 mode0 before timeout", 1'b0);
    tick();        check("R7 mode0 timeout", 1'b1);

    // R8 sof_bad when locked
    lock_mode = 1; fclr();
    sof_bad = 1; tick(); sof_bad = 0;
    check("R8 bad strobe sets", 1'b1);
    fclr();
    ticks(HI - 2); check("R8 restart before", 1'b0);
    tick();        check("R8 restart period", 1'b1);

    // R10 out-of-window spacing drops lock
    sof_pulse(); ticks(199); sof_pulse(); fclr();
    ticks(HI - 1); check("R10 unlocked at period", 1'b0);
    ticks(TMO - HI - 1); check("R10 before timeout", 1'b0);
    tick();        check("R10 timeout", 1'b1);

    // R6 just above window does not lock
    bus_rst(); sof_pulse(); ticks(HI); sof_pulse(); fclr();
    ticks(HI - 1); check("R6 above window no lock", 1'b0);
    ticks(TMO - HI - 1); check("R6 above window before timeout", 1'b0);
    tick();        check("R6 above window timeout", 1'b1);

    // R6 lower window edge locks
    bus_rst(); sof_pulse(); ticks(LO - 1); sof_pulse(); fclr();
    ticks(LO - 2); check("R6 lower edge before", 1'b0);
    tick();        check("R6 lower edge locks", 1'b1);

    // R9 real SOF restarts counter
    lock_mode = 0; sof_pulse(); ticks(299); sof_pulse(); fclr();
    ticks(TMO - 2); check("R9 before timeout from last SOF", 1'b0);
    tick();         check("R9 timeout from last SOF", 1'b1);

    // R4 bus reset clears flag and restarts counter
    bus_rst(); check("R4 bus reset clears", 1'b0);
    ticks(TMO - 1); check("R4 counter restart before", 1'b0);
    tick();         check("R4 counter restart timeout", 1'b1);
    rst_n = 0; tick(); check("R4 local reset clears", 1'b0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule